// File: doc/BRIEF.md
# Command Frame Header Parser

This block sits between a host byte-stream interface and the command-execution logic. It takes a command frame one byte per cycle, with an end-of-frame marker on the final byte. The first ten bytes form a fixed big-endian header: a 16-bit tag, a 32-bit total frame size and a 32-bit command code. The parser reports the decoded header together with the parameter length that follows it. The tag tells downstream logic whether an authorization-session area is present. All bytes after the header are forwarded unchanged. The parser does not execute commands, evaluate sessions or perform any cryptography.

Each frame is checked against the tag encodings, the request-buffer capacity and the number of bytes actually received. At the end of every frame the block reports success or failure and the number of parameter bytes it forwarded. A malformed frame makes the block send a fixed ten-byte failure response on its own byte-stream response port. Input is held off until that response has been fully taken.

Top module: `cmd_frame_parser`

## Requirements
- R1: After reset `in_ready` is 1, and `rsp_valid`, `hdr_valid`, `par_valid` and `done` are all 0.
- R2: Bytes 0-1 form the tag, bytes 2-5 the size and bytes 6-9 the code, each most significant byte first. When the tenth byte is accepted with a legal tag and an in-range size, `hdr_valid` pulses one cycle later. With it come these fields and `hdr_param_len` = size - 10, before any parameter byte appears.
- R3: Tag 16'hC001 means no session area (`hdr_has_sess` = 0). Tag 16'hC002 means a session area follows (`hdr_has_sess` = 1).
- R4: Every byte at frame index 10 up to size-1 appears on `par_data` with `par_valid`, unchanged and in order, one cycle after it is accepted. Bytes at index size or beyond are never forwarded.
- R5: One cycle after the byte marked `in_last` is accepted, `done` pulses. `done_err` is 0 only if the frame was well formed. `done_count` gives the number of parameter bytes forwarded for that frame.
- R6: A tag other than the two legal values causes a tag failure. No header is reported, no byte of that frame is forwarded, and the rest of the frame is discarded up to `in_last`.
- R7: A size failure results when the frame ends before ten bytes, when the size field is below 10, or when the received byte count differs from the size field. Checks run in header order, and the first failing field decides the code.
- R8: A size field above BUF_BYTES (default 4096) causes an oversize failure. A size of exactly BUF_BYTES is accepted.
- R9: A failure response is exactly ten bytes, each MSB first: tag 16'hC001, size 32'd10, then the response code. `rsp_last` marks the tenth byte, and a byte is held stable while `rsp_ready` is 0.
- R10: `in_ready` is 0 whenever `rsp_valid` is 1, so no byte of a following frame is taken while a response is pending.
- R11: A response code has bit 7 set as the failure flag, bits 11:8 naming the faulty header field (1 tag, 2 size) and bits 3:0 the fault class (1 tag, 2 size, 3 oversize), with all other bits 0. This gives 32'h181, 32'h282 and 32'h283.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request byte valid |
| in_data | input | 8 | Request byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Request byte accepted when high with in_valid |
| hdr_valid | output | 1 | One-cycle pulse: header fields valid |
| hdr_tag | output | 16 | Decoded tag |
| hdr_size | output | 32 | Decoded total frame size |
| hdr_code | output | 32 | Decoded command code |
| hdr_has_sess | output | 1 | Session area follows the parameters |
| hdr_param_len | output | 32 | Size minus header length |
| par_valid | output | 1 | Parameter byte valid |
| par_data | output | 8 | Parameter byte |
| done | output | 1 | One-cycle pulse at frame end |
| done_err | output | 1 | Frame was malformed |
| done_count | output | 13 | Parameter bytes forwarded for the frame |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Response byte taken |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final response byte |

## Verification
Well-formed frames are sent with each tag: one carrying four parameter bytes, one that is header only, and one exactly at buffer capacity. These separate session decoding, field byte order and the capacity boundary. Malformed frames cover each failure path. They include an illegal tag that also ends early, which shows tag-before-size priority. An oversize field in a truncated frame shows oversize-before-length priority. Short, long and under-ten size cases separate the three length checks, and the over-long case also shows that bytes beyond the size are not forwarded. One response is drained under alternating `rsp_ready`, and one failure is followed at once by a good frame, to show that input is held off until the response is consumed.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    localparam int HDR_BYTES = 10;
    localparam logic [15:0] TAG_PLAIN = 16'hC001;
    localparam logic [15:0] TAG_SESS  = 16'hC002;

    typedef enum logic [1:0] {
        FLT_NONE,
        FLT_TAG,
        FLT_SIZE,
        FLT_BIG
    } fault_e;

    typedef enum logic [1:0] {
        ST_HDR,
        ST_BODY,
        ST_DRAIN
    } parse_st_e;

    typedef struct packed {
        logic [15:0] tag;
        logic [31:0] size;
        logic [31:0] code;
    } hdr_t;

    function automatic logic tag_legal(logic [15:0] t);
        return (t == TAG_PLAIN) || (t == TAG_SESS);
    endfunction

    function automatic logic [31:0] fault_code(fault_e f);
        logic [3:0] field;
        logic [3:0] cls;
        case (f)
            FLT_TAG:  begin field = 4'd1; cls = 4'd1; end
            FLT_SIZE: begin field = 4'd2; cls = 4'd2; end
            FLT_BIG:  begin field = 4'd2; cls = 4'd3; end
            default:  begin field = 4'd0; cls = 4'd0; end
        endcase
        return (f == FLT_NONE) ? 32'h0 : {20'h0, field, 1'b1, 3'b000, cls};
    endfunction

endpackage

// File: rtl/cfp_hdr_capture.sv
module cfp_hdr_capture
    import cfp_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             clear,
    input  logic [7:0]       byte_i,
    output logic [IDX_W-1:0] idx_o,
    output hdr_t             hdr_nx_o
);

    logic [IDX_W-1:0] idx_q;
    hdr_t             hdr_q;
    logic             in_hdr;

    assign in_hdr = idx_q < IDX_W'(HDR_BYTES);

    always_comb begin
        if (take && in_hdr) begin
            hdr_nx_o = hdr_t'({hdr_q[71:0], byte_i});
        end else begin
            hdr_nx_o = hdr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            hdr_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
            if (in_hdr) begin
                hdr_q <= hdr_nx_o;
            end
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/cfp_frame_check.sv
module cfp_frame_check
    import cfp_pkg::*;
#(
    parameter int BUF_BYTES = 4096,
    parameter int IDX_W     = 13
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             last,
    input  logic [63:0]      nx_low,
    output fault_e           fault,
    output logic             hdr_fire,
    output logic             fwd,
    output logic             end_ok
);

    logic [31:0] pos;
    logic [31:0] fsize;

    assign pos   = 32'(idx);
    assign fsize = nx_low[63:32];

    always_comb begin
        fault    = FLT_NONE;
        hdr_fire = 1'b0;
        fwd      = 1'b0;
        end_ok   = 1'b0;
        if (pos < 32'(HDR_BYTES)) begin
            if (pos == 32'd1 && !tag_legal(nx_low[15:0])) begin
                fault = FLT_TAG;
            end else if (pos == 32'd5 && nx_low[31:0] < 32'(HDR_BYTES)) begin
                fault = FLT_SIZE;
            end else if (pos == 32'd5 && nx_low[31:0] > 32'(BUF_BYTES)) begin
                fault = FLT_BIG;
            end else if (pos == 32'(HDR_BYTES - 1)) begin
                hdr_fire = 1'b1;
                if (last) begin
                    if (fsize == 32'(HDR_BYTES)) end_ok = 1'b1;
                    else                          fault  = FLT_SIZE;
                end
            end else if (last) begin
                fault = FLT_SIZE;
            end
        end else begin
            if (pos >= fsize) begin
                fault = FLT_SIZE;
            end else begin
                fwd = 1'b1;
                if (last) begin
                    if (pos + 32'd1 == fsize) end_ok = 1'b1;
                    else                       fault  = FLT_SIZE;
                end
            end
        end
    end

endmodule

// File: rtl/cfp_rsp_tx.sv
module cfp_rsp_tx
    import cfp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] code,
    output logic        busy,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [7:0]  rsp_data,
    output logic        rsp_last
);

    localparam int RSP_BYTES = HDR_BYTES;

    logic [3:0]  pos_q;
    logic [31:0] code_q;
    logic        busy_q;
    logic [79:0] word;

    assign word      = {TAG_PLAIN, 32'(RSP_BYTES), code_q};
    assign busy      = busy_q;
    assign rsp_valid = busy_q;
    assign rsp_last  = busy_q && (pos_q == 4'(RSP_BYTES - 1));
    assign rsp_data  = word[8*(RSP_BYTES - 1 - int'(pos_q)) +: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
            code_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                pos_q  <= '0;
                code_q <= code;
            end
        end else if (rsp_ready) begin
            if (rsp_last) begin
                busy_q <= 1'b0;
                pos_q  <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
    import cfp_pkg::*;
#(
    parameter int BUF_BYTES = 4096
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [7:0]                       in_data,
    input  logic                             in_last,
    output logic                             in_ready,
    output logic                             hdr_valid,
    output logic [15:0]                      hdr_tag,
    output logic [31:0]                      hdr_size,
    output logic [31:0]                      hdr_code,
    output logic                             hdr_has_sess,
    output logic [31:0]                      hdr_param_len,
    output logic                             par_valid,
    output logic [7:0]                       par_data,
    output logic                             done,
    output logic                             done_err,
    output logic [$clog2(BUF_BYTES+1)-1:0]   done_count,
    output logic                             rsp_valid,
    input  logic                             rsp_ready,
    output logic [7:0]                       rsp_data,
    output logic                             rsp_last
);

    localparam int IDX_W = $clog2(BUF_BYTES + 1);

    parse_st_e        st_q;
    fault_e           fault;
    fault_e           fault_q;
    hdr_t             hdr_nx;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] cnt_q;
    logic             acc;
    logic             parse_acc;
    logic             hdr_fire;
    logic             fwd;
    logic             end_ok;
    logic             has_fault;
    logic             clear;
    logic             start_rsp;
    logic [31:0]      rsp_code;
    logic             busy;

    assign in_ready  = !busy;
    assign acc       = in_valid && in_ready;
    assign parse_acc = acc && (st_q != ST_DRAIN);
    assign has_fault = (fault != FLT_NONE);
    assign clear     = parse_acc && (has_fault || end_ok);
    assign start_rsp = acc && in_last && ((st_q == ST_DRAIN) || (parse_acc && has_fault));
    assign rsp_code  = (st_q == ST_DRAIN) ? fault_code(fault_q) : fault_code(fault);

    cfp_hdr_capture #(.IDX_W(IDX_W)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .take     (parse_acc),
        .clear    (clear),
        .byte_i   (in_data),
        .idx_o    (idx),
        .hdr_nx_o (hdr_nx)
    );

    cfp_frame_check #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) chk_i (
        .idx      (idx),
        .last     (in_last),
        .nx_low   (hdr_nx[63:0]),
        .fault    (fault),
        .hdr_fire (hdr_fire),
        .fwd      (fwd),
        .end_ok   (end_ok)
    );

    cfp_rsp_tx tx_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start_rsp),
        .code      (rsp_code),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_HDR;
            fault_q <= FLT_NONE;
        end else if (st_q == ST_DRAIN) begin
            if (acc && in_last) st_q <= ST_HDR;
        end else if (parse_acc) begin
            if (has_fault) begin
                fault_q <= fault;
                st_q    <= in_last ? ST_HDR : ST_DRAIN;
            end else if (end_ok) begin
                st_q <= ST_HDR;
            end else if (hdr_fire) begin
                st_q <= ST_BODY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_valid     <= 1'b0;
            hdr_tag       <= '0;
            hdr_size      <= '0;
            hdr_code      <= '0;
            hdr_has_sess  <= 1'b0;
            hdr_param_len <= '0;
        end else begin
            hdr_valid <= parse_acc && hdr_fire;
            if (parse_acc && hdr_fire) begin
                hdr_tag       <= hdr_nx.tag;
                hdr_size      <= hdr_nx.size;
                hdr_code      <= hdr_nx.code;
                hdr_has_sess  <= (hdr_nx.tag == TAG_SESS);
                hdr_param_len <= hdr_nx.size - 32'(HDR_BYTES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_valid  <= 1'b0;
            par_data   <= '0;
            cnt_q      <= '0;
            done       <= 1'b0;
            done_err   <= 1'b0;
            done_count <= '0;
        end else begin
            par_valid <= parse_acc && fwd;
            if (parse_acc && fwd) par_data <= in_data;
            done <= acc && in_last;
            if (acc && in_last) begin
                done_err   <= !(parse_acc && end_ok);
                done_count <= cnt_q + IDX_W'(parse_acc && fwd);
                cnt_q      <= '0;
            end else if (parse_acc && fwd) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfp_chk.sv
module cfp_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_last,
    input logic       par_valid,
    input logic       done,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [7:0] rsp_data,
    input logic       rsp_last
);

    // R10
    hold_input_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !in_ready);

    // R9
    rsp_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R9
    rsp_last_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);

    // R4
    par_src_chk: assert property (@(posedge clk) disable iff (rst)
        par_valid |-> $past(in_valid && in_ready));

    // R5
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_ready && in_last));

endmodule

bind cmd_frame_parser cfp_chk cfp_chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .par_valid (par_valid),
    .done      (done),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last)
);

// File: tb/cmd_frame_parser_tb_top.sv
`timescale 1ns/100ps
module cmd_frame_parser_tb_top;

    localparam int BUF = 4096;
    localparam logic [31:0] C_TAG  = 32'h181;
    localparam logic [31:0] C_SIZE = 32'h282;
    localparam logic [31:0] C_BIG  = 32'h283;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        hdr_valid;
    logic [15:0] hdr_tag;
    logic [31:0] hdr_size;
    logic [31:0] hdr_code;
    logic        hdr_has_sess;
    logic [31:0] hdr_param_len;
    logic        par_valid;
    logic [7:0]  par_data;
    logic        done;
    logic        done_err;
    logic [12:0] done_count;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [7:0]  rsp_data;
    logic        rsp_last;

    int errs = 0;
    int checks = 0;
    bit stall_mode = 1'b0;

    always #2 clk = ~clk;

    cmd_frame_parser #(.BUF_BYTES(BUF)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .hdr_valid(hdr_valid), .hdr_tag(hdr_tag), .hdr_size(hdr_size), .hdr_code(hdr_code),
        .hdr_has_sess(hdr_has_sess), .hdr_param_len(hdr_param_len),
        .par_valid(par_valid), .par_data(par_data),
        .done(done), .done_err(done_err), .done_count(done_count),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    // monitor state
    int          cyc = 0;
    int          hdr_n, par_n, done_n, rsp_n, rsp_last_at, viol, hdr_cyc, par_cyc;
    logic [15:0] m_tag;
    logic [31:0] m_size, m_code, m_plen;
    logic        m_sess, m_err;
    int          m_cnt;
    logic [7:0]  par_buf [0:BUF-1];
    logic [7:0]  rsp_buf [0:15];

    always @(posedge clk) begin
        #1 rsp_ready = stall_mode ? ~rsp_ready : 1'b1;
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (hdr_valid) begin
                hdr_n++; hdr_cyc = cyc;
                m_tag = hdr_tag; m_size = hdr_size; m_code = hdr_code;
                m_sess = hdr_has_sess; m_plen = hdr_param_len;
            end
            if (par_valid) begin
                if (par_n == 0) par_cyc = cyc;
                if (par_n < BUF) par_buf[par_n] = par_data;
                par_n++;
            end
            if (done) begin
                done_n++; m_err = done_err; m_cnt = int'(done_count);
            end
            if (rsp_valid && in_ready) viol++;
            if (rsp_valid && rsp_ready) begin
                if (rsp_n < 16) rsp_buf[rsp_n] = rsp_data;
                if (rsp_last) rsp_last_at = rsp_n;
                rsp_n++;
            end
        end
    end

    task automatic mon_clear();
        hdr_n = 0; par_n = 0; done_n = 0; rsp_n = 0; rsp_last_at = -1; viol = 0;
        hdr_cyc = 0; par_cyc = 0; m_err = 1'b0; m_cnt = -1;
    endtask

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(logic [79:0] h, int i);
        if (i < 10) return h[8*(9-i) +: 8];
        return 8'(i * 13 + 5);
    endfunction

    task automatic put_byte(logic [7:0] b, logic l);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_last = l;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send(logic [15:0] tag, logic [31:0] size, logic [31:0] code, int nbytes);
        logic [79:0] h;
        h = {tag, size, code};
        for (int i = 0; i < nbytes; i++) put_byte(fb(h, i), i == nbytes - 1);
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic check_rsp(logic [31:0] exp_code, string req);
        logic [79:0] w;
        w = {16'hC001, 32'd10, exp_code};
        chk(rsp_n == 10, "R9 response length", rsp_n, 10);
        chk(rsp_last_at == 9, "R9 rsp_last position", rsp_last_at, 9);
        for (int i = 0; i < 10; i++)
            chk(rsp_buf[i] == w[8*(9-i) +: 8], req, rsp_buf[i], w[8*(9-i) +: 8]);
        chk(viol == 0, "R10 in_ready during response", viol, 0);
        chk(done_n == 1 && m_err == 1'b1, "R5 done with error", m_err, 1);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(!rsp_valid && !hdr_valid && !par_valid && !done, "R1 outputs idle",
            {rsp_valid, hdr_valid, par_valid, done}, 0);
    endtask

    task automatic t_plain();
        mon_clear();
        send(16'hC001, 32'd14, 32'h1122_3344, 14);
        settle();
        chk(hdr_n == 1, "R2 header pulse", hdr_n, 1);
        chk(m_tag == 16'hC001 && m_size == 14 && m_code == 32'h1122_3344, "R2 fields",
            {m_tag, m_size, m_code}, {16'hC001, 32'd14, 32'h1122_3344});
        chk(m_plen == 4, "R2 param length", m_plen, 4);
        chk(hdr_cyc < par_cyc, "R2 length before data", hdr_cyc, par_cyc);
        chk(m_sess == 1'b0, "R3 plain tag", m_sess, 0);
        chk(par_n == 4, "R4 forwarded count", par_n, 4);
        for (int i = 0; i < 4; i++)
            chk(par_buf[i] == fb('0, i + 10), "R4 param byte", par_buf[i], fb('0, i + 10));
        chk(done_n == 1 && m_err == 1'b0 && m_cnt == 4, "R5 good frame end",
            {m_err, 32'(m_cnt)}, {1'b0, 32'd4});
        chk(rsp_n == 0, "R9 no response for good frame", rsp_n, 0);
    endtask

    task automatic t_sess();
        mon_clear();
        send(16'hC002, 32'd10, 32'hABCD_0001, 10);
        settle();
        chk(hdr_n == 1 && m_sess == 1'b1, "R3 session tag", m_sess, 1);
        chk(m_plen == 0 && par_n == 0, "R4 header-only frame", par_n, 0);
        chk(done_n == 1 && m_err == 1'b0 && m_cnt == 0, "R5 header-only end", m_cnt, 0);
    endtask

    task automatic t_bad_tag();
        mon_clear();
        send(16'h8001, 32'd14, 32'h5, 14);
        settle();
        chk(hdr_n == 0 && par_n == 0, "R6 nothing forwarded", hdr_n + par_n, 0);
        check_rsp(C_TAG, "R11 tag code");
    endtask

    task automatic t_tag_then_short();
        mon_clear();
        send(16'h1234, 32'd14, 32'h5, 2);
        settle();
        check_rsp(C_TAG, "R7 tag precedes short");
    endtask

    task automatic t_short();
        mon_clear();
        send(16'hC001, 32'd14, 32'h5, 5);
        settle();
        chk(hdr_n == 0, "R7 short no header", hdr_n, 0);
        check_rsp(C_SIZE, "R7 short frame code");
    endtask

    task automatic t_truncated();
        mon_clear();
        stall_mode = 1'b1;
        send(16'hC002, 32'd20, 32'h7, 15);
        settle();
        stall_mode = 1'b0;
        chk(hdr_n == 1, "R7 header before mismatch", hdr_n, 1);
        check_rsp(C_SIZE, "R9 stalled response");
    endtask

    task automatic t_overlong();
        mon_clear();
        send(16'hC001, 32'd12, 32'h7, 14);
        settle();
        chk(par_n == 2, "R4 bytes past size dropped", par_n, 2);
        check_rsp(C_SIZE, "R7 overlong code");
    endtask

    task automatic t_small_size();
        mon_clear();
        send(16'hC001, 32'd8, 32'h7, 10);
        settle();
        chk(hdr_n == 0, "R7 size below ten no header", hdr_n, 0);
        check_rsp(C_SIZE, "R7 size below ten code");
    endtask

    task automatic t_big();
        mon_clear();
        send(16'hC001, 32'd5000, 32'h7, 12);
        settle();
        chk(hdr_n == 0, "R8 oversize no header", hdr_n, 0);
        check_rsp(C_BIG, "R8 oversize beats length");
        mon_clear();
        send(16'hC002, 32'(BUF + 1), 32'h7, 20);
        settle();
        check_rsp(C_BIG, "R8 capacity plus one");
    endtask

    task automatic t_full();
        int bad;
        mon_clear();
        send(16'hC001, 32'(BUF), 32'h99, BUF);
        settle();
        bad = 0;
        for (int i = 0; i < BUF - 10; i++) if (par_buf[i] != fb('0, i + 10)) bad++;
        chk(hdr_n == 1 && m_plen == BUF - 10, "R8 capacity header", m_plen, BUF - 10);
        chk(bad == 0, "R8 capacity payload", bad, 0);
        chk(done_n == 1 && m_err == 1'b0 && m_cnt == BUF - 10, "R8 capacity accepted",
            m_cnt, BUF - 10);
    endtask

    task automatic t_back_to_back();
        mon_clear();
        send(16'h0000, 32'd10, 32'h1, 4);
        send(16'hC001, 32'd11, 32'h42, 11);
        settle();
        chk(viol == 0, "R10 held during response", viol, 0);
        chk(rsp_n == 10 && rsp_buf[9] == 8'h81, "R10 response intact", rsp_buf[9], 8'h81);
        chk(hdr_n == 1 && m_code == 32'h42 && par_n == 1, "R10 next frame intact",
            m_code, 32'h42);
    endtask

    initial begin
        #(4 * 150000);
        errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        mon_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_sess();
        t_bad_tag();
        t_tag_then_short();
        t_short();
        t_truncated();
        t_overlong();
        t_small_size();
        t_big();
        t_full();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule